// File: doc/BRIEF.md
# Ethernet Receive Frame Acceptance Controller

This block stands between a byte-wide receive path and the packet memory writer, and decides for every incoming frame whether it is kept. A frame is only picked up when the receiver is enabled and carrier sense is qualified. Qualification can include a leading-edge glitch filter counted in bit-time ticks. Each started frame then has its destination address checked against the station address, the multicast rules, broadcast and promiscuous mode. A frame that arrives while the local transmitter is busy in half duplex is refused. Kept bytes go out on a memory write stream, with the trailing frame check sequence removed on request.

Incoming bytes pass through a six-stage delay line. No byte reaches memory before the decision, and the last four bytes can be withheld at the end of the frame. Every started frame ends with exactly one outcome pulse. The accept pulse comes with the last written byte. The discard pulse tells the memory writer to roll back what it holds for that frame. An oversize frame is cut off, discarded and recorded in a sticky abort flag.

Top module: `rx_accept_ctrl`

## Requirements
- R1: With `filterCarrier` = 1 a frame start is taken only after `carrierSense` has been high for 12 `bitTick` pulses, counted since carrier last rose. With `filterCarrier` = 0 a start is taken whenever `carrierSense` is high. A start beat without qualified carrier makes the whole frame ignored: no write and no pulse.
- R2: `rxEnable` is sampled only on the start beat. A frame started while it is 1 finishes normally even if it drops mid-frame. Later starts are ignored while it is 0.
- R3: Destination byte k (k = 0..5, in arrival order) is compared with `stationAddr[8k+7:8k]`. A unicast frame is kept only when all six bytes match.
- R4: A frame is multicast when bit 0 of its first byte is 1. With `allMulticast` = 1 every multicast frame is kept. Otherwise it is kept only if `mcastHit` is 1 on the sixth byte's beat, except that broadcast (six bytes 0xFF) is always kept.
- R5: With `promiscuous` = 1 every frame passes the address check.
- R6: If `fullDuplex` = 0 and `txBusy` = 1 on the start beat, the frame is discarded, even in promiscuous mode. With `fullDuplex` = 1, `txBusy` has no effect.
- R7: A kept frame of N bytes writes its bytes in arrival order. It writes N bytes when `stripCrc` (sampled on the end beat) is 0, and the first N-4 bytes when it is 1.
- R8: A frame longer than 1532 bytes is discarded and sets `rxAbort`, while a 1532-byte frame is kept. `rxAbort` stays set until reset or an `abortClear` pulse, and a new abort in the same cycle wins over the clear.
- R9: A started frame shorter than 6 bytes is discarded.
- R10: Each started frame yields exactly one pulse, never both. `frameAccepted` comes in the same cycle as the last `memWrite`. `frameDiscarded` comes after the end beat. A frame refused by address, duplex or length rules before its sixth byte writes nothing. All outputs are 0 after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| carrierSense | input | 1 | Carrier present on the medium |
| bitTick | input | 1 | One pulse per bit time |
| filterCarrier | input | 1 | Enable carrier leading-edge filter |
| rxValid | input | 1 | Receive byte valid |
| rxStart | input | 1 | First byte of frame (with rxValid) |
| rxEnd | input | 1 | Last byte of frame (with rxValid) |
| rxByte | input | 8 | Receive byte |
| rxEnable | input | 1 | Receiver enable |
| fullDuplex | input | 1 | Full-duplex mode |
| txBusy | input | 1 | Local transmitter is sending |
| promiscuous | input | 1 | Keep all frames |
| allMulticast | input | 1 | Keep all multicast frames |
| mcastHit | input | 1 | Multicast table hit for current frame |
| stripCrc | input | 1 | Drop the trailing 4 bytes |
| stationAddr | input | 48 | Station individual address |
| abortClear | input | 1 | Clear the sticky abort flag |
| memData | output | 8 | Byte to packet memory |
| memWrite | output | 1 | Write strobe for memData |
| frameAccepted | output | 1 | Frame kept (with last write) |
| frameDiscarded | output | 1 | Frame dropped, roll back |
| rxAbort | output | 1 | Sticky oversize abort flag |

## Verification
The hardest states to reach are the length boundary and the carrier filter edge. For the length boundary, the stimulus sends frames of exactly 1532 and 1533 bytes and follows the 1533-byte one with a normal frame and a clear pulse, to show the flag is sticky. For the filter edge, the stimulus drops carrier, raises it again and gives exactly 11 and then 12 manual bit ticks before a start. A receive-enable drop in the middle of a frame, and a frame of exactly six bytes with stripping on, cover the delay-line flush. Random frames with random idle gaps inside them mix every address class and mode bit.

// File: rtl/rxacc_pkg.sv
package rxacc_pkg;
  typedef struct packed {
    logic shift;
    logic emit;
  } dpStrobe_t;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_RECV,
    ST_FLUSH
  } rxState_t;
endpackage

// File: rtl/rxacc_datapath.sv
module rxacc_datapath
  import rxacc_pkg::*;
#(
  parameter int ADDR_BYTES = 6
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  dpStrobe_t               str,
  input  logic [7:0]              rxByte,
  input  logic [8*ADDR_BYTES-1:0] stationAddr,
  output logic                    isMcast,
  output logic                    isBcast,
  output logic                    uniMatch,
  output logic [7:0]              memData,
  output logic                    memWrite
);
  localparam int LAST = ADDR_BYTES - 1;

  logic [7:0] line [ADDR_BYTES];
  logic [7:0] daByte [ADDR_BYTES];
  logic [ADDR_BYTES-1:0] byteEq;
  logic [ADDR_BYTES-1:0] byteOnes;

  // Destination view on the sixth-byte beat: older bytes sit deeper in the line.
  for (genvar k = 0; k < ADDR_BYTES; k++) begin : g_da
    if (k == LAST) begin : g_cur
      assign daByte[k] = rxByte;
    end else begin : g_old
      assign daByte[k] = line[LAST-1-k];
    end
    assign byteEq[k]   = (daByte[k] == stationAddr[8*k +: 8]);
    assign byteOnes[k] = (daByte[k] == 8'hFF);
  end

  assign isMcast  = daByte[0][0];
  assign isBcast  = &byteOnes;
  assign uniMatch = &byteEq;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < ADDR_BYTES; i++) line[i] <= '0;
      memData  <= '0;
      memWrite <= 1'b0;
    end else begin
      memWrite <= str.shift && str.emit;
      if (str.shift) begin
        line[0] <= rxByte;
        for (int i = 1; i < ADDR_BYTES; i++) line[i] <= line[i-1];
        if (str.emit) memData <= line[LAST];
      end
    end
  end

  // R10: every write leaves through the delay line on a shift
  a_r10_write_on_shift: assert property (@(posedge clk) disable iff (!rstN)
    (str.shift && str.emit) |=> memWrite);
endmodule

// File: rtl/rxacc_ctrl.sv
module rxacc_ctrl
  import rxacc_pkg::*;
#(
  parameter int MAX_LEN      = 1532,
  parameter int CARRIER_BITS = 12,
  parameter int ADDR_BYTES   = 6,
  parameter int FCS_BYTES    = 4
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      carrierSense,
  input  logic      bitTick,
  input  logic      filterCarrier,
  input  logic      rxValid,
  input  logic      rxStart,
  input  logic      rxEnd,
  input  logic      rxEnable,
  input  logic      fullDuplex,
  input  logic      txBusy,
  input  logic      promiscuous,
  input  logic      allMulticast,
  input  logic      mcastHit,
  input  logic      stripCrc,
  input  logic      abortClear,
  input  logic      isMcast,
  input  logic      isBcast,
  input  logic      uniMatch,
  output dpStrobe_t str,
  output logic      frameAccepted,
  output logic      frameDiscarded,
  output logic      rxAbort
);
  localparam int LEN_W = $clog2(MAX_LEN + 2);
  localparam int CAR_W = $clog2(CARRIER_BITS + 1);
  localparam int FL_W  = $clog2(ADDR_BYTES + 1);

  rxState_t         state;
  logic [LEN_W-1:0] byteCnt;
  logic [CAR_W-1:0] carrierCnt;
  logic [FL_W-1:0]  flushLeft;
  logic             accepted, aborted, selfBlk;

  logic carrierOk, startBeat, lastDa, accNow, abortNow, abortSet, keep;

  assign carrierOk = carrierSense &&
                     (!filterCarrier || carrierCnt == CAR_W'(CARRIER_BITS));
  assign startBeat = (state == ST_IDLE) && rxValid && rxStart && carrierOk && rxEnable;
  assign lastDa    = (byteCnt == LEN_W'(ADDR_BYTES - 1));
  assign accNow    = !selfBlk &&
                     (promiscuous || (isMcast ? (isBcast || allMulticast || mcastHit) : uniMatch));
  assign abortNow  = (byteCnt == LEN_W'(MAX_LEN));
  assign abortSet  = (state == ST_RECV) && rxValid && abortNow;
  assign keep      = !aborted && !abortNow && (lastDa ? accNow : accepted);

  always_comb begin
    str.shift = startBeat || (state == ST_RECV && rxValid) || (state == ST_FLUSH);
    str.emit  = (state == ST_FLUSH) ||
                (state == ST_RECV && accepted && !aborted && byteCnt >= LEN_W'(ADDR_BYTES));
  end

  // Carrier qualification counter
  always_ff @(posedge clk) begin
    if (!rstN || !carrierSense) carrierCnt <= '0;
    else if (bitTick && carrierCnt < CAR_W'(CARRIER_BITS)) carrierCnt <= carrierCnt + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state          <= ST_IDLE;
      byteCnt        <= '0;
      flushLeft      <= '0;
      accepted       <= 1'b0;
      aborted        <= 1'b0;
      selfBlk        <= 1'b0;
      frameAccepted  <= 1'b0;
      frameDiscarded <= 1'b0;
      rxAbort        <= 1'b0;
    end else begin
      frameAccepted  <= 1'b0;
      frameDiscarded <= 1'b0;
      if (abortSet)        rxAbort <= 1'b1;
      else if (abortClear) rxAbort <= 1'b0;
      unique case (state)
        ST_IDLE: if (startBeat) begin
          byteCnt  <= LEN_W'(1);
          selfBlk  <= !fullDuplex && txBusy;
          accepted <= 1'b0;
          aborted  <= 1'b0;
          if (rxEnd) frameDiscarded <= 1'b1;
          else       state <= ST_RECV;
        end
        ST_RECV: if (rxValid) begin
          if (byteCnt <= LEN_W'(MAX_LEN)) byteCnt <= byteCnt + 1'b1;
          if (lastDa)   accepted <= accNow;
          if (abortNow) aborted  <= 1'b1;
          if (rxEnd) begin
            if (keep) begin
              state     <= ST_FLUSH;
              flushLeft <= stripCrc ? FL_W'(ADDR_BYTES - FCS_BYTES) : FL_W'(ADDR_BYTES);
            end else begin
              state          <= ST_IDLE;
              frameDiscarded <= 1'b1;
            end
          end
        end
        ST_FLUSH: begin
          flushLeft <= flushLeft - 1'b1;
          if (flushLeft == FL_W'(1)) begin
            frameAccepted <= 1'b1;
            state         <= ST_IDLE;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  a_r1_no_start_without_carrier: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_IDLE && !carrierSense) |=> (state == ST_IDLE && !frameDiscarded));
  a_r2_idle_when_disabled: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_IDLE && !rxEnable) |=> (state == ST_IDLE && !frameDiscarded));
  a_r8_abort_sticky: assert property (@(posedge clk) disable iff (!rstN)
    (rxAbort && !abortClear) |=> rxAbort);
  a_r10_single_outcome: assert property (@(posedge clk) disable iff (!rstN)
    !(frameAccepted && frameDiscarded));
  a_r7_flush_bounded: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_FLUSH) |-> (flushLeft != '0));
endmodule

// File: rtl/rx_accept_ctrl.sv
module rx_accept_ctrl
  import rxacc_pkg::*;
#(
  parameter int MAX_LEN      = 1532,
  parameter int CARRIER_BITS = 12,
  parameter int ADDR_BYTES   = 6,
  parameter int FCS_BYTES    = 4
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    carrierSense,
  input  logic                    bitTick,
  input  logic                    filterCarrier,
  input  logic                    rxValid,
  input  logic                    rxStart,
  input  logic                    rxEnd,
  input  logic [7:0]              rxByte,
  input  logic                    rxEnable,
  input  logic                    fullDuplex,
  input  logic                    txBusy,
  input  logic                    promiscuous,
  input  logic                    allMulticast,
  input  logic                    mcastHit,
  input  logic                    stripCrc,
  input  logic [8*ADDR_BYTES-1:0] stationAddr,
  input  logic                    abortClear,
  output logic [7:0]              memData,
  output logic                    memWrite,
  output logic                    frameAccepted,
  output logic                    frameDiscarded,
  output logic                    rxAbort
);
  dpStrobe_t str;
  logic isMcast, isBcast, uniMatch;

  rxacc_ctrl #(
    .MAX_LEN(MAX_LEN), .CARRIER_BITS(CARRIER_BITS),
    .ADDR_BYTES(ADDR_BYTES), .FCS_BYTES(FCS_BYTES)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .carrierSense(carrierSense), .bitTick(bitTick),
    .filterCarrier(filterCarrier), .rxValid(rxValid), .rxStart(rxStart),
    .rxEnd(rxEnd), .rxEnable(rxEnable), .fullDuplex(fullDuplex), .txBusy(txBusy),
    .promiscuous(promiscuous), .allMulticast(allMulticast), .mcastHit(mcastHit),
    .stripCrc(stripCrc), .abortClear(abortClear), .isMcast(isMcast),
    .isBcast(isBcast), .uniMatch(uniMatch), .str(str),
    .frameAccepted(frameAccepted), .frameDiscarded(frameDiscarded), .rxAbort(rxAbort)
  );

  rxacc_datapath #(.ADDR_BYTES(ADDR_BYTES)) u_dp (
    .clk(clk), .rstN(rstN), .str(str), .rxByte(rxByte), .stationAddr(stationAddr),
    .isMcast(isMcast), .isBcast(isBcast), .uniMatch(uniMatch),
    .memData(memData), .memWrite(memWrite)
  );
endmodule

// File: tb/rx_accept_ctrl_tb.sv
module rx_accept_ctrl_tb;
  localparam int CLK_PERIOD = 10;
  localparam int MAX_LEN    = 1532;

  logic clk = 0, rstN = 0;
  logic carrierSense = 0, bitTick = 0, filterCarrier = 0;
  logic rxValid = 0, rxStart = 0, rxEnd = 0;
  logic [7:0] rxByte = 0;
  logic rxEnable = 0, fullDuplex = 0, txBusy = 0, promiscuous = 0;
  logic allMulticast = 0, mcastHit = 0, stripCrc = 0, abortClear = 0;
  logic [47:0] stationAddr = 48'h5A_4E_3D_2C_1B_02;
  logic [7:0] memData;
  logic memWrite, frameAccepted, frameDiscarded, rxAbort;

  int checks = 0, fails = 0;
  int gotAcc = 0, gotDisc = 0;
  logic [7:0] gotBytes[$];
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rx_accept_ctrl u_dut (
    .clk(clk), .rstN(rstN), .carrierSense(carrierSense), .bitTick(bitTick),
    .filterCarrier(filterCarrier), .rxValid(rxValid), .rxStart(rxStart), .rxEnd(rxEnd),
    .rxByte(rxByte), .rxEnable(rxEnable), .fullDuplex(fullDuplex), .txBusy(txBusy),
    .promiscuous(promiscuous), .allMulticast(allMulticast), .mcastHit(mcastHit),
    .stripCrc(stripCrc), .stationAddr(stationAddr), .abortClear(abortClear),
    .memData(memData), .memWrite(memWrite), .frameAccepted(frameAccepted),
    .frameDiscarded(frameDiscarded), .rxAbort(rxAbort)
  );

  always @(negedge clk) if (rstN) begin
    if (memWrite) gotBytes.push_back(memData);
    if (frameAccepted) gotAcc++;
    if (frameDiscarded) gotDisc++;
  end

  task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic void model(input logic [7:0] f[$], input bit started,
                                output logic [7:0] e[$], output int ea, output int ed);
    int n;
    bit mc, bc, un, ok;
    e = {}; ea = 0; ed = 0;
    if (!started) return;
    n = f.size();
    if (n < 6 || n > MAX_LEN) begin ed = 1; return; end
    mc = f[0][0]; bc = 1; un = 1;
    for (int k = 0; k < 6; k++) begin
      if (f[k] != 8'hFF) bc = 0;
      if (f[k] != stationAddr[8*k +: 8]) un = 0;
    end
    ok = !(txBusy && !fullDuplex) && (promiscuous || (mc ? (bc || allMulticast || mcastHit) : un));
    if (!ok) ed = 1;
    else begin
      ea = 1;
      for (int i = 0; i < (stripCrc ? n - 4 : n); i++) e.push_back(f[i]);
    end
  endfunction

  function automatic void makeFrame(input int kind, input int len, output logic [7:0] f[$]);
    f = {};
    for (int k = 0; k < 6; k++) begin
      case (kind)
        0: f.push_back(stationAddr[8*k +: 8]);
        1: f.push_back(8'hFF);
        default: f.push_back(8'($urandom));
      endcase
    end
    if (kind == 2) f[0][0] = 1'b1;
    if (kind == 2 && f[1] == 8'hFF) f[1] = 8'h10;
    if (kind == 3) f[0][0] = 1'b0;
    if (kind == 4) f[5] = f[5] ^ 8'h01;
    for (int i = 6; i < len; i++) f.push_back(8'($urandom));
    while (f.size() > len) void'(f.pop_back());
  endfunction

  task automatic sendFrame(input logic [7:0] f[$], input int gapMax, input int disableAt);
    for (int i = 0; i < f.size(); i++) begin
      if (gapMax > 0) begin
        rxValid = 0; rxStart = 0; rxEnd = 0;
        repeat ($urandom_range(gapMax, 0)) @(negedge clk);
      end
      rxValid = 1; rxByte = f[i]; rxStart = (i == 0); rxEnd = (i == f.size() - 1);
      @(negedge clk);
      if (i == disableAt) rxEnable = 0;
    end
    rxValid = 0; rxStart = 0; rxEnd = 0;
    repeat (12) @(negedge clk);
  endtask

  task automatic doFrame(input logic [7:0] f[$], input bit started, input int gapMax,
                         input int disableAt, input string req, input bit cmpBytes);
    logic [7:0] e[$];
    int ea, ed;
    bit same;
    model(f, started, e, ea, ed);
    gotBytes = {}; gotAcc = 0; gotDisc = 0;
    sendFrame(f, gapMax, disableAt);
    if (cmpBytes) begin
      same = (gotBytes.size() == e.size());
      if (same) foreach (e[i]) if (gotBytes[i] != e[i]) same = 0;
      check(same, req, "written byte count/content", gotBytes.size(), e.size());
    end
    check(gotAcc == ea, req, "accept pulses", gotAcc, ea);
    check(gotDisc == ed, req, "discard pulses", gotDisc, ed);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [7:0] f[$];
    void'($urandom(32'd2024));
    repeat (4) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    // R10 reset state
    check(!memWrite && !frameAccepted && !frameDiscarded, "R10", "outputs after reset", memWrite, 0);
    check(!rxAbort, "R8", "abort after reset", rxAbort, 0);

    carrierSense = 1; bitTick = 1; rxEnable = 1; fullDuplex = 1;
    repeat (20) @(negedge clk);

    makeFrame(0, 20, f); doFrame(f, 1, 0, -1, "R3 own unicast", 1);
    stripCrc = 1; makeFrame(0, 20, f); doFrame(f, 1, 0, -1, "R7 strip", 1);
    makeFrame(0, 6, f); doFrame(f, 1, 0, -1, "R7 six-byte strip", 1);
    stripCrc = 0;
    makeFrame(4, 16, f); doFrame(f, 1, 0, -1, "R3 last byte differs", 1);
    makeFrame(3, 16, f); doFrame(f, 1, 0, -1, "R3 foreign unicast", 1);
    makeFrame(2, 16, f); mcastHit = 0; doFrame(f, 1, 0, -1, "R4 mcast miss", 1);
    mcastHit = 1; doFrame(f, 1, 0, -1, "R4 mcast hit", 1);
    mcastHit = 0; allMulticast = 1; doFrame(f, 1, 0, -1, "R4 all multicast", 1);
    allMulticast = 0;
    makeFrame(1, 16, f); doFrame(f, 1, 0, -1, "R4 broadcast", 1);
    promiscuous = 1; makeFrame(3, 16, f); doFrame(f, 1, 0, -1, "R5 promiscuous", 1);
    fullDuplex = 0; txBusy = 1; doFrame(f, 1, 0, -1, "R6 self block", 1);
    fullDuplex = 1; doFrame(f, 1, 0, -1, "R6 full duplex ignores txBusy", 1);
    txBusy = 0; promiscuous = 0;
    makeFrame(0, 4, f); doFrame(f, 1, 0, -1, "R9 runt", 1);

    // R8 length boundary and sticky flag
    makeFrame(0, MAX_LEN, f); doFrame(f, 1, 0, -1, "R8 max length kept", 1);
    check(!rxAbort, "R8", "no abort at max length", rxAbort, 0);
    makeFrame(0, MAX_LEN + 1, f); doFrame(f, 1, 0, -1, "R8 oversize", 0);
    check(rxAbort, "R8", "abort set", rxAbort, 1);
    makeFrame(0, 12, f); doFrame(f, 1, 0, -1, "R8 after abort", 1);
    check(rxAbort, "R8", "abort sticky", rxAbort, 1);
    abortClear = 1; @(negedge clk); abortClear = 0; @(negedge clk);
    check(!rxAbort, "R8", "abort cleared", rxAbort, 0);

    // R1 carrier filter
    filterCarrier = 1; bitTick = 0;
    carrierSense = 0; @(negedge clk); carrierSense = 1;
    bitTick = 1; repeat (11) @(negedge clk); bitTick = 0;
    makeFrame(0, 12, f); doFrame(f, 0, 0, -1, "R1 eleven ticks", 1);
    bitTick = 1; @(negedge clk); bitTick = 0;
    doFrame(f, 1, 0, -1, "R1 twelve ticks", 1);
    filterCarrier = 0; carrierSense = 0; @(negedge clk); carrierSense = 1;
    doFrame(f, 1, 0, -1, "R1 filter off", 1);
    carrierSense = 0; @(negedge clk);
    doFrame(f, 0, 0, -1, "R1 no carrier", 1);
    carrierSense = 1; bitTick = 1;

    // R2 graceful disable
    makeFrame(0, 14, f); doFrame(f, 1, 0, 2, "R2 disable mid-frame", 1);
    doFrame(f, 0, 0, -1, "R2 disabled start", 1);
    rxEnable = 1;

    // Random mix
    for (int n = 0; n < 60; n++) begin
      int kind, len;
      kind = $urandom_range(4, 0);
      len = $urandom_range(30, 3);
      stripCrc = $urandom; promiscuous = ($urandom_range(7, 0) == 0);
      allMulticast = $urandom; mcastHit = $urandom; filterCarrier = $urandom;
      fullDuplex = $urandom; txBusy = ($urandom_range(3, 0) == 0);
      makeFrame(kind, len, f);
      doFrame(f, 1, 3, -1, "R7 random", 1);
    end
    txBusy = 0;

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule